// File: doc/BRIEF.md
# Locked-Rotor Detector with Timed Retry

This block supervises a single-phase fan bridge by watching the tachometer level for changes. While the rotor turns, every tachometer change restarts a lock window measured in ticks of a slow timebase. If the window runs out with no change, the block declares a locked rotor. It raises a lock flag, turns off the high-side (source) drivers and holds both low-side drivers on, which brakes the winding.

While locked, the block alternates between a long braking interval and a short drive interval in a fixed 15:1 ratio. If the tachometer changes during a drive interval, the fault clears and normal running resumes with a fresh window. A low drive-enable request forces the block back to running at any time and holds the window at zero.

Default sizes are a window of 8 ticks, a brake of 120 ticks and a retry drive of 8 ticks. With a tick of 125 ms, these give a 1 s window, 15 s off and 1 s on.

Top module: `rotorLockDetect`

## Requirements
- R1: After reset `lockFlag`, `srcDisable` and `holdSinks` are low, and the lock window counts from the release of reset.
- R2: While running, the lock is declared on the WINDOW_TICKS-th (default 8th) `oscTick` pulse with no tachometer change since the last change, reset or re-enable. The outputs change in the cycle after the clock edge that samples that tick; 7 ticks leave the outputs low.
- R3: While running, a tachometer change in either direction restarts the window. A change sampled at the same edge as a tick wins, and that tick is not counted.
- R4: On entry to the lock, `lockFlag`, `srcDisable` and `holdSinks` go high together. `srcDisable` and `holdSinks` always carry equal values.
- R5: The brake interval lasts OFF_TICKS (default 120) ticks. Tachometer changes during the brake are ignored: the brake continues and its length does not change.
- R6: After the brake, a retry interval of ON_TICKS (default 8) ticks follows. During it `srcDisable` and `holdSinks` are low and `lockFlag` stays high. If the rotor stays still, the block then returns to a full brake.
- R7: A tachometer change during a retry interval drops `lockFlag` in the next cycle and returns the block to running with a fresh window of WINDOW_TICKS ticks.
- R8: While `driveEn` is low, the block is held in running with all outputs low, one cycle after `driveEn` is sampled low, and the window stays at zero whatever the ticks do. Counting starts from zero once `driveEn` is high again.
- R9: `lockFlag` is high exactly while the fault is active (brake or retry), so `srcDisable` high implies `lockFlag` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tachIn | input | 1 | Tachometer level, synchronous to clk |
| oscTick | input | 1 | One-cycle pulse per timebase period |
| driveEn | input | 1 | Drive-enable request; low clears the fault |
| lockFlag | output | 1 | High while the locked-rotor fault is active |
| srcDisable | output | 1 | High turns the source drivers off |
| holdSinks | output | 1 | High holds both low-side drivers on |

## Verification
The assertions watch every cycle for several properties. Both braking commands always move together. A braking command never appears without the lock flag. A lock is only entered with the braking commands, and only after a full window of ticks counted since the last tachometer change. The brake cannot end without a tick, and the lock drops after a change during retry and after a low enable. Only the bench scenarios show the exact brake and retry lengths, the repeated brake after a failed retry, the fresh window after recovery, and the priority of a change over a tick sampled at the same edge.

// File: rtl/rotorLockPkg.sv
package rotorLockPkg;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_BRAKE = 2'd1,
    PH_RETRY = 2'd2
  } phase_t;

  // commands from control to the tick counter
  typedef struct packed {
    logic   clr;
    logic   inc;
    phase_t limSel;
  } cntCmd_t;

  // status from the datapath back to control
  typedef struct packed {
    logic tachEdge;
    logic atLimit;
  } cntStat_t;

endpackage

// File: rtl/rldDatapath.sv
module rldDatapath
  import rotorLockPkg::*;
#(
  parameter int WINDOW_TICKS = 8,
  parameter int OFF_TICKS    = 120,
  parameter int ON_TICKS     = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tachIn,
  input  cntCmd_t  cmd,
  output cntStat_t stat
);

  localparam int MAX_A     = (WINDOW_TICKS > ON_TICKS) ? WINDOW_TICKS : ON_TICKS;
  localparam int MAX_TICKS = (MAX_A > OFF_TICKS) ? MAX_A : OFF_TICKS;
  localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WINDOW_TICKS - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);

  logic             tachQ;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tachQ <= 1'b0;
    else       tachQ <= tachIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tickCnt <= '0;
    else if (cmd.clr) tickCnt <= '0;
    else if (cmd.inc) tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    unique case (cmd.limSel)
      PH_BRAKE: limit = OFF_LAST;
      PH_RETRY: limit = ON_LAST;
      default:  limit = WIN_LAST;
    endcase
  end

  assign stat.tachEdge = tachIn ^ tachQ;
  assign stat.atLimit  = (tickCnt == limit);

endmodule

// File: rtl/rldCtrl.sv
module rldCtrl
  import rotorLockPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     oscTick,
  input  logic     driveEn,
  input  cntStat_t stat,
  output cntCmd_t  cmd,
  output logic     lockFlag,
  output logic     srcDisable,
  output logic     holdSinks
);

  phase_t phase, phaseNxt;

  always_comb begin
    phaseNxt = phase;
    cmd.clr  = 1'b0;
    cmd.inc  = 1'b0;
    cmd.limSel = phase;
    if (!driveEn) begin
      phaseNxt = PH_RUN;
      cmd.clr  = 1'b1;
    end else begin
      unique case (phase)
        PH_RUN: begin
          if (stat.tachEdge) cmd.clr = 1'b1;
          else if (oscTick) begin
            if (stat.atLimit) begin
              phaseNxt = PH_BRAKE;
              cmd.clr  = 1'b1;
            end else cmd.inc = 1'b1;
          end
        end
        PH_BRAKE: begin
          if (oscTick) begin
            if (stat.atLimit) begin
              phaseNxt = PH_RETRY;
              cmd.clr  = 1'b1;
            end else cmd.inc = 1'b1;
          end
        end
        PH_RETRY: begin
          if (stat.tachEdge) begin
            phaseNxt = PH_RUN;
            cmd.clr  = 1'b1;
          end else if (oscTick) begin
            if (stat.atLimit) begin
              phaseNxt = PH_BRAKE;
              cmd.clr  = 1'b1;
            end else cmd.inc = 1'b1;
          end
        end
        default: begin
          phaseNxt = PH_RUN;
          cmd.clr  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_RUN;
      lockFlag   <= 1'b0;
      srcDisable <= 1'b0;
      holdSinks  <= 1'b0;
    end else begin
      phase      <= phaseNxt;
      lockFlag   <= (phaseNxt != PH_RUN);
      srcDisable <= (phaseNxt == PH_BRAKE);
      holdSinks  <= (phaseNxt == PH_BRAKE);
    end
  end

endmodule

// File: rtl/rotorLockDetect.sv
module rotorLockDetect
  import rotorLockPkg::*;
#(
  parameter int WINDOW_TICKS = 8,
  parameter int OFF_TICKS    = 120,
  parameter int ON_TICKS     = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic tachIn,
  input  logic oscTick,
  input  logic driveEn,
  output logic lockFlag,
  output logic srcDisable,
  output logic holdSinks
);

  cntCmd_t  cmd;
  cntStat_t stat;

  rldDatapath #(
    .WINDOW_TICKS(WINDOW_TICKS),
    .OFF_TICKS   (OFF_TICKS),
    .ON_TICKS    (ON_TICKS)
  ) uDatapath (
    .clk   (clk),
    .rstN  (rstN),
    .tachIn(tachIn),
    .cmd   (cmd),
    .stat  (stat)
  );

  rldCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .oscTick   (oscTick),
    .driveEn   (driveEn),
    .stat      (stat),
    .cmd       (cmd),
    .lockFlag  (lockFlag),
    .srcDisable(srcDisable),
    .holdSinks (holdSinks)
  );

endmodule

// File: rtl/rotorLockDetectChk.sv
module rotorLockDetectChk #(
  parameter int WINDOW_TICKS = 8
) (
  input logic clk,
  input logic rstN,
  input logic tachIn,
  input logic oscTick,
  input logic driveEn,
  input logic lockFlag,
  input logic srcDisable,
  input logic holdSinks
);

  localparam int W = $clog2(WINDOW_TICKS + 2);

  logic         tachSeen;
  logic [W-1:0] quietTicks;
  logic         tachChange;

  assign tachChange = tachIn ^ tachSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tachSeen   <= 1'b0;
      quietTicks <= '0;
    end else begin
      tachSeen <= tachIn;
      if (!driveEn || tachChange) quietTicks <= '0;
      else if (oscTick && quietTicks < W'(WINDOW_TICKS)) quietTicks <= quietTicks + 1'b1;
    end
  end

  assert_brake_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    srcDisable == holdSinks);

  assert_src_implies_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    srcDisable |-> lockFlag);

  assert_lock_enters_brake_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> srcDisable);

  assert_full_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!lockFlag && driveEn && !tachChange && oscTick && quietTicks == W'(WINDOW_TICKS - 1))
      |=> lockFlag);

  assert_no_early_lock_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!lockFlag && !(driveEn && !tachChange && oscTick && quietTicks == W'(WINDOW_TICKS - 1)))
      |=> !lockFlag);

  assert_brake_needs_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (srcDisable && driveEn && !oscTick) |=> srcDisable);

  assert_retry_recover_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlag && !srcDisable && driveEn && tachChange) |=> !lockFlag);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |=> (!lockFlag && !srcDisable));

endmodule

bind rotorLockDetect rotorLockDetectChk #(.WINDOW_TICKS(WINDOW_TICKS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .tachIn    (tachIn),
  .oscTick   (oscTick),
  .driveEn   (driveEn),
  .lockFlag  (lockFlag),
  .srcDisable(srcDisable),
  .holdSinks (holdSinks)
);

// File: tb/rotorLockDetect_test.sv
module rotorLockDetect_test;

  localparam int WIN = 8;
  localparam int OFF = 120;
  localparam int ON  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tachIn = 1'b0;
  logic oscTick = 1'b0;
  logic driveEn = 1'b1;
  logic lockFlag, srcDisable, holdSinks;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rotorLockDetect #(.WINDOW_TICKS(WIN), .OFF_TICKS(OFF), .ON_TICKS(ON)) uut (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .oscTick(oscTick), .driveEn(driveEn),
    .lockFlag(lockFlag), .srcDisable(srcDisable), .holdSinks(holdSinks)
  );

  function automatic bit expectLocked(int quiet);
    return quiet >= WIN;
  endfunction

  task automatic chkOut(string req, logic eLock, logic eSrc, logic eSink);
    tests++;
    if (lockFlag !== eLock || srcDisable !== eSrc || holdSinks !== eSink) begin
      fails++;
      $display("FAIL %s: actual lock=%b src=%b sinks=%b expected lock=%b src=%b sinks=%b",
               req, lockFlag, srcDisable, holdSinks, eLock, eSrc, eSink);
    end
  endtask

  task automatic ticks(int n, int maxIdle = 0);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, maxIdle)) @(negedge clk);
      @(negedge clk) oscTick = 1'b1;
      @(negedge clk) oscTick = 1'b0;
    end
  endtask

  task automatic toggleTach();
    @(negedge clk) tachIn = ~tachIn;
    @(negedge clk);
  endtask

  task automatic clearFault();
    @(negedge clk) driveEn = 1'b0;
    @(negedge clk) driveEn = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4930));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkOut("R1 reset state", 0, 0, 0);

    // R2/R4: window counted from reset
    ticks(7);
    chkOut("R2 seven ticks no lock", 0, 0, 0);
    ticks(1);
    chkOut("R2 R4 lock on eighth tick", 1, 1, 1);

    // R5: tach change in brake ignored, brake length
    toggleTach();
    chkOut("R5 tach ignored in brake", 1, 1, 1);
    ticks(119);
    chkOut("R5 brake after 119 ticks", 1, 1, 1);
    ticks(1);
    chkOut("R6 retry starts after 120 ticks", 1, 0, 0);
    ticks(7);
    chkOut("R6 retry after 7 ticks", 1, 0, 0);
    ticks(1);
    chkOut("R6 back to brake after 8 ticks", 1, 1, 1);
    ticks(120);
    chkOut("R6 second retry", 1, 0, 0);

    // R7: recovery in retry, fresh window
    toggleTach();
    chkOut("R7 recover on tach change", 0, 0, 0);
    ticks(7);
    chkOut("R7 fresh window 7 ticks", 0, 0, 0);
    ticks(1);
    chkOut("R7 fresh window lock at 8", 1, 1, 1);

    // R8: enable low clears and holds window
    @(negedge clk) driveEn = 1'b0;
    @(negedge clk);
    chkOut("R8 clear on driveEn low", 0, 0, 0);
    ticks(16);
    chkOut("R8 no count while disabled", 0, 0, 0);
    driveEn = 1'b1;
    ticks(7);
    chkOut("R8 restart 7 ticks", 0, 0, 0);
    ticks(1);
    chkOut("R8 restart lock at 8", 1, 1, 1);

    // R3: plain restart
    clearFault();
    ticks(7);
    toggleTach();
    ticks(7);
    chkOut("R3 restart by tach change", 0, 0, 0);
    ticks(1);
    chkOut("R3 lock after restart", 1, 1, 1);

    // R3: change and tick at the same edge
    clearFault();
    ticks(7);
    @(negedge clk) begin tachIn = ~tachIn; oscTick = 1'b1; end
    @(negedge clk) oscTick = 1'b0;
    chkOut("R3 same-edge change wins", 0, 0, 0);
    ticks(7);
    chkOut("R3 same-edge tick not counted", 0, 0, 0);
    ticks(1);
    chkOut("R3 same-edge lock at 8", 1, 1, 1);

    // random quiet lengths with random tick spacing (R2, R3, R4, R9)
    for (int t = 0; t < 40; t++) begin
      int quiet;
      clearFault();
      toggleTach();
      quiet = $urandom_range(3, 12);
      ticks(quiet, 3);
      if (expectLocked(quiet)) chkOut("R2 R9 random quiet locks", 1, 1, 1);
      else                     chkOut("R3 random quiet no lock", 0, 0, 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule